// File: doc/BRIEF.md
# Serial Controller Block Mover

This block copies one fixed 64-byte block between main memory and a 64-byte scratch RAM that it holds inside. Two separate triggers choose the direction: one loads the scratch RAM from memory, and the other stores the scratch RAM back to memory. A memory base address is presented with the trigger. The block first clears the low three bits of that address. It then moves sixteen 32-bit words in ascending address order and reverses the byte order of each word on the way. When the copy is done it raises a completion interrupt, either at once or after a fixed delay.

Memory traffic uses two valid/ready channels. On the request channel, `mem_req_valid_o` stays high, and address, direction and data stay unchanged, until the cycle in which `mem_req_ready_i` is high. That cycle is the transfer. At most one read is outstanding at a time. On the response channel, a beat is taken in a cycle where both `mem_rsp_valid_i` and `mem_rsp_ready_o` are high. `mem_rsp_ready_o` is high only while a read is outstanding. A command engine outside the block reads and writes the scratch RAM through a plain word-wide host port with a combinational read path.

The base address is read as a signed number. Addresses above the configured memory size are refused. Negative word positions never reach the memory bus.

Top module: `serblk_dma`

## Requirements
- R1: Every accepted transfer covers exactly 16 word positions (64 bytes) at base+0, base+4, …, base+60 in ascending order, and issues at most 16 memory requests.
- R2: The base is the presented address with bits [2:0] forced to zero, so every request address has bits [1:0] equal to zero.
- R3: In both directions each word is byte-reversed: memory word {b3,b2,b1,b0} (b3 in bits 31:24) becomes scratch word {b0,b1,b2,b3}, and the reverse applies toward memory.
- R4: A trigger whose address, read as signed, is greater than DRAM_BYTES is dropped. No request is issued, busy stays low, no interrupt is raised, and the scratch RAM is unchanged.
- R5: Word positions with a negative address (bit 31 set) issue no request. Toward the scratch RAM, those words load zero. Toward memory, those words are skipped.
- R6: On completion both `irq_si_o` and `stat_irq_o` are set.
- R7: With `delay_en_i` high when the last word completes, the interrupts rise exactly DELAY_CYCLES cycles later than they would with the delay option off.
- R8: `busy_o` stays high from acceptance until the copy and any pending delay are over. Triggers that arrive while busy is high are ignored.
- R9: `stat_wr_i` clears `stat_irq_o` and `irq_ack_i` clears `irq_si_o`. Each one touches only its own bit. A completion in the same cycle wins over the clear.
- R10: A request that is not accepted holds its valid, address and direction until it is accepted.
- R11: If both triggers rise in the same cycle, the memory-to-scratch direction is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go_to_scratch_i | input | 1 | Start a memory-to-scratch copy |
| go_to_dram_i | input | 1 | Start a scratch-to-memory copy |
| dram_addr_i | input | 32 | Memory base byte address (signed) |
| delay_en_i | input | 1 | Delay the completion interrupt |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request ready |
| mem_req_write_o | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr_o | output | 32 | Request byte address |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_ready_o | output | 1 | Read response ready |
| mem_rsp_data_i | input | 32 | Read response data |
| host_idx_i | input | 4 | Scratch word index for the host port |
| host_we_i | input | 1 | Host write enable |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (combinational) |
| busy_o | output | 1 | Copy or delay pending |
| stat_irq_o | output | 1 | Status interrupt bit |
| stat_wr_i | input | 1 | Status write, clears `stat_irq_o` |
| irq_si_o | output | 1 | Interrupt line to the interrupt controller |
| irq_ack_i | input | 1 | Clears `irq_si_o` |

## Verification
The bench starts a copy from an address with low bits 101 and checks that every word lands at the aligned base. A design that masked the wrong bits would shift all sixteen words. It starts copies from a negative base that crosses zero, in both directions. A design that sent those positions to memory, or left stale scratch data in them, would be caught by the request count and the zero words. An address just above the memory size, and triggers sent while the delay is pending, must both leave memory, scratch RAM and interrupts untouched. A design that let either through would show extra requests. The cycle count of the delayed interrupt is compared with the immediate case, so an off-by-one delay counter shows as a mismatch of one cycle.

// File: rtl/serblk_dma_pkg.sv
`timescale 1ns/1ps
package serblk_dma_pkg;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_ISSUE = 2'd1,
    MV_WAIT  = 2'd2
  } mv_state_t;

  typedef enum logic {
    DIR_TO_SCR  = 1'b0,
    DIR_TO_DRAM = 1'b1
  } dir_t;

  // reverse byte order of a word
  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/serblk_scratch.sv
`timescale 1ns/1ps
module serblk_scratch #(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_we_i,
  input  logic [IDX_W-1:0] dma_idx_i,
  input  logic [DW-1:0]    dma_wdata_i,
  output logic [DW-1:0]    dma_rdata_o,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_idx_i,
  input  logic [DW-1:0]    host_wdata_i,
  output logic [DW-1:0]    host_rdata_o
);

  logic [DW-1:0] mem_q [WORDS];

  // one register per word; the mover port wins a same-word collision
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (dma_we_i && dma_idx_i == IDX_W'(g)) begin
        mem_q[g] <= dma_wdata_i;
      end else if (host_we_i && host_idx_i == IDX_W'(g)) begin
        mem_q[g] <= host_wdata_i;
      end
    end
  end

  assign dma_rdata_o  = mem_q[dma_idx_i];
  assign host_rdata_o = mem_q[host_idx_i];

endmodule

// File: rtl/serblk_mover.sv
`timescale 1ns/1ps
module serblk_mover
  import serblk_dma_pkg::*;
#(
  parameter int      ADDR_W     = 32,
  parameter int      WORDS      = 16,
  parameter int      ALIGN_BITS = 3,
  parameter longint  DRAM_BYTES = 64'h0080_0000,
  localparam int     IDX_W      = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_scr_i,
  input  logic              go_dram_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [31:0]       req_wdata_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [31:0]       rsp_data_i,
  output logic              scr_we_o,
  output logic [IDX_W-1:0]  scr_idx_o,
  output logic [31:0]       scr_wdata_o,
  input  logic [31:0]       scr_rdata_i,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic signed [ADDR_W-1:0] SIZE_S = ADDR_W'(DRAM_BYTES);
  localparam logic [IDX_W-1:0]         LAST   = IDX_W'(WORDS - 1);

  mv_state_t         state_q;
  dir_t              dir_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;

  logic [ADDR_W-1:0] word_addr;
  logic              neg_pos;
  logic              in_range;
  logic              step;
  logic              last;

  assign in_range  = !($signed(addr_i) > SIZE_S);
  assign word_addr = base_q + {{(ADDR_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
  assign neg_pos   = word_addr[ADDR_W-1];
  assign last      = (idx_q == LAST);

  always_comb begin
    step = 1'b0;
    unique case (state_q)
      MV_ISSUE: step = neg_pos || (dir_q == DIR_TO_DRAM && req_ready_i);
      MV_WAIT:  step = rsp_valid_i;
      default:  step = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      dir_q   <= DIR_TO_SCR;
      idx_q   <= '0;
      base_q  <= '0;
    end else begin
      unique case (state_q)
        MV_IDLE: begin
          if ((go_scr_i || go_dram_i) && in_range) begin
            state_q <= MV_ISSUE;
            idx_q   <= '0;
            base_q  <= {addr_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            dir_q   <= go_scr_i ? DIR_TO_SCR : DIR_TO_DRAM;
          end
        end
        MV_ISSUE, MV_WAIT: begin
          if (step) begin
            if (last) begin
              state_q <= MV_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= MV_ISSUE;
            end
          end else if (state_q == MV_ISSUE && dir_q == DIR_TO_SCR && req_ready_i) begin
            state_q <= MV_WAIT;
          end
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == MV_ISSUE) && !neg_pos;
  assign req_write_o = (dir_q == DIR_TO_DRAM);
  assign req_addr_o  = word_addr;
  assign req_wdata_o = swap32(scr_rdata_i);
  assign rsp_ready_o = (state_q == MV_WAIT);

  assign scr_idx_o   = idx_q;
  assign scr_we_o    = (dir_q == DIR_TO_SCR) &&
                       ((state_q == MV_ISSUE && neg_pos) ||
                        (state_q == MV_WAIT && rsp_valid_i));
  assign scr_wdata_o = (state_q == MV_WAIT) ? swap32(rsp_data_i) : 32'h0;

  assign busy_o = (state_q != MV_IDLE);
  assign done_o = step && last;

endmodule

// File: rtl/serblk_irq.sv
`timescale 1ns/1ps
module serblk_irq #(
  parameter int  DELAY_CYCLES = 2304,
  localparam int CNT_W        = $clog2(DELAY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic delay_en_i,
  input  logic stat_wr_i,
  input  logic irq_ack_i,
  output logic pend_o,
  output logic stat_irq_o,
  output logic irq_si_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             fire;

  assign fire = (done_i && !delay_en_i) ||
                (pend_q && cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (done_i && delay_en_i) begin
      pend_q <= 1'b1;
      cnt_q  <= CNT_W'(DELAY_CYCLES);
    end else if (pend_q) begin
      if (cnt_q == CNT_W'(1)) begin
        pend_q <= 1'b0;
      end
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_irq_o <= 1'b0;
      irq_si_o   <= 1'b0;
    end else begin
      if (fire)           stat_irq_o <= 1'b1;
      else if (stat_wr_i) stat_irq_o <= 1'b0;
      if (fire)           irq_si_o   <= 1'b1;
      else if (irq_ack_i) irq_si_o   <= 1'b0;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/serblk_dma.sv
`timescale 1ns/1ps
module serblk_dma
  import serblk_dma_pkg::*;
#(
  parameter int     ADDR_W       = 32,
  parameter int     BLOCK_BYTES  = 64,
  parameter int     ALIGN_BITS   = 3,
  parameter longint DRAM_BYTES   = 64'h0080_0000,
  parameter int     DELAY_CYCLES = 2304,
  localparam int    WORDS        = BLOCK_BYTES / 4,
  localparam int    IDX_W        = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_to_scratch_i,
  input  logic              go_to_dram_i,
  input  logic [ADDR_W-1:0] dram_addr_i,
  input  logic              delay_en_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [31:0]       mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [31:0]       mem_rsp_data_i,
  input  logic [IDX_W-1:0]  host_idx_i,
  input  logic              host_we_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  output logic              busy_o,
  output logic              stat_irq_o,
  input  logic              stat_wr_i,
  output logic              irq_si_o,
  input  logic              irq_ack_i
);

  logic             mv_busy;
  logic             mv_done;
  logic             irq_pend;
  logic             go_scr;
  logic             go_dram;
  logic             scr_we;
  logic [IDX_W-1:0] scr_idx;
  logic [31:0]      scr_wdata;
  logic [31:0]      scr_rdata;

  assign busy_o  = mv_busy || irq_pend;
  assign go_scr  = go_to_scratch_i && !busy_o;
  assign go_dram = go_to_dram_i && !busy_o;

  serblk_mover #(
    .ADDR_W     (ADDR_W),
    .WORDS      (WORDS),
    .ALIGN_BITS (ALIGN_BITS),
    .DRAM_BYTES (DRAM_BYTES)
  ) mover_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_scr_i    (go_scr),
    .go_dram_i   (go_dram),
    .addr_i      (dram_addr_i),
    .req_valid_o (mem_req_valid_o),
    .req_ready_i (mem_req_ready_i),
    .req_write_o (mem_req_write_o),
    .req_addr_o  (mem_req_addr_o),
    .req_wdata_o (mem_req_wdata_o),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_ready_o (mem_rsp_ready_o),
    .rsp_data_i  (mem_rsp_data_i),
    .scr_we_o    (scr_we),
    .scr_idx_o   (scr_idx),
    .scr_wdata_o (scr_wdata),
    .scr_rdata_i (scr_rdata),
    .busy_o      (mv_busy),
    .done_o      (mv_done)
  );

  serblk_scratch #(
    .WORDS (WORDS),
    .DW    (32)
  ) scratch_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .dma_we_i     (scr_we),
    .dma_idx_i    (scr_idx),
    .dma_wdata_i  (scr_wdata),
    .dma_rdata_o  (scr_rdata),
    .host_we_i    (host_we_i),
    .host_idx_i   (host_idx_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o)
  );

  serblk_irq #(
    .DELAY_CYCLES (DELAY_CYCLES)
  ) irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (mv_done),
    .delay_en_i (delay_en_i),
    .stat_wr_i  (stat_wr_i),
    .irq_ack_i  (irq_ack_i),
    .pend_o     (irq_pend),
    .stat_irq_o (stat_irq_o),
    .irq_si_o   (irq_si_o)
  );

endmodule

// File: rtl/serblk_dma_chk.sv
`timescale 1ns/1ps
module serblk_dma_chk #(
  parameter int     ADDR_W     = 32,
  parameter int     WORDS      = 16,
  parameter longint DRAM_BYTES = 64'h0080_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go_a,
  input logic              go_b,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              stat_irq,
  input logic              irq_si,
  input logic              stat_wr,
  input logic              irq_ack
);

  localparam logic signed [ADDR_W-1:0] SIZE_S = ADDR_W'(DRAM_BYTES);
  localparam int CW = $clog2(WORDS + 2);

  logic [CW-1:0] req_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      req_cnt <= '0;
    else if (!busy)                  req_cnt <= '0;
    else if (req_valid && req_ready) req_cnt <= req_cnt + 1'b1;
  end

  assert_req_budget_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_cnt <= CW'(WORDS));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00);

  assert_drop_far_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((go_a || go_b) && !busy && ($signed(addr) > SIZE_S)) |=> !busy);

  assert_no_neg_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !req_addr[ADDR_W-1]);

  assert_both_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_irq) |-> irq_si);

  assert_req_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !busy) |=> !stat_irq);

  assert_si_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !busy) |=> !irq_si);

  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_write));

endmodule

bind serblk_dma serblk_dma_chk #(
  .ADDR_W     (ADDR_W),
  .WORDS      (WORDS),
  .DRAM_BYTES (DRAM_BYTES)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .go_a      (go_to_scratch_i),
  .go_b      (go_to_dram_i),
  .addr      (dram_addr_i),
  .busy      (busy_o),
  .req_valid (mem_req_valid_o),
  .req_ready (mem_req_ready_i),
  .req_write (mem_req_write_o),
  .req_addr  (mem_req_addr_o),
  .stat_irq  (stat_irq_o),
  .irq_si    (irq_si_o),
  .stat_wr   (stat_wr_i),
  .irq_ack   (irq_ack_i)
);

// File: tb/serblk_dma_tb_top.sv
`timescale 1ns/1ps
module serblk_dma_tb_top;

  localparam int          DELAY = 2304;
  localparam logic [31:0] SIZE  = 32'h0080_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go_scr = 1'b0, go_dram = 1'b0, delay_en = 1'b0;
  logic [31:0] addr = '0;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_data;
  logic [3:0]  h_idx = '0;
  logic        h_we = 1'b0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic        busy, stat_irq, irq_si;
  logic        stat_wr = 1'b0, irq_ack = 1'b0;

  int total = 0, bad = 0;
  int rcnt = 0, wcnt = 0;
  logic [31:0] wlog [16];
  logic [31:0] cur_base = '0;
  logic        bp_en = 1'b1;
  logic [7:0]  lfsr = 8'hA7;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  serblk_dma #(.DELAY_CYCLES(DELAY)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .go_to_scratch_i(go_scr), .go_to_dram_i(go_dram),
    .dram_addr_i(addr), .delay_en_i(delay_en),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
    .mem_req_write_o(req_write), .mem_req_addr_o(req_addr),
    .mem_req_wdata_o(req_wdata),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_ready_o(rsp_ready),
    .mem_rsp_data_i(rsp_data),
    .host_idx_i(h_idx), .host_we_i(h_we), .host_wdata_i(h_wdata),
    .host_rdata_o(h_rdata),
    .busy_o(busy), .stat_irq_o(stat_irq), .stat_wr_i(stat_wr),
    .irq_si_o(irq_si), .irq_ack_i(irq_ack)
  );

  function automatic logic [31:0] mdat(input logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h1234_5678;
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // memory model
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    req_ready <= bp_en ? lfsr[0] : 1'b1;
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (req_valid && req_ready && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mdat(req_addr);
        rcnt <= rcnt + 1;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (req_valid && req_ready && req_write) begin
        wlog[4'((req_addr - cur_base) >> 2)] <= req_wdata;
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd_scr(input int i, output logic [31:0] v);
    @(negedge clk);
    h_idx = 4'(i);
    #1 v = h_rdata;
  endtask

  task automatic wr_scr(input int i, input logic [31:0] v);
    @(negedge clk);
    h_idx = 4'(i); h_wdata = v; h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic kick(input bit to_scr, input bit to_dram, input logic [31:0] a);
    @(negedge clk);
    addr = a; go_scr = to_scr; go_dram = to_dram;
    cur_base = {a[31:3], 3'b000};
    @(negedge clk);
    go_scr = 1'b0; go_dram = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic clear_irqs();
    @(negedge clk); stat_wr = 1'b1; irq_ack = 1'b1;
    @(negedge clk); stat_wr = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !stat_irq && !irq_si && !req_valid, "R8 reset idle",
        {28'h0, busy, stat_irq, irq_si, req_valid}, 32'h0);
  endtask

  task automatic t_load_aligned();
    logic [31:0] v;
    int r0 = rcnt;
    kick(1'b1, 1'b0, 32'h0000_1235);
    wait_idle();
    chk(rcnt - r0 == 16, "R1 read count", rcnt - r0, 16);
    for (int i = 0; i < 16; i++) begin
      rd_scr(i, v);
      chk(v == bswap(mdat(32'h1230 + 4 * i)), "R2 R3 load word", v, bswap(mdat(32'h1230 + 4 * i)));
    end
    chk(stat_irq && irq_si, "R6 both bits set", {30'h0, stat_irq, irq_si}, 32'h3);
  endtask

  task automatic t_clear();
    @(negedge clk); stat_wr = 1'b1;
    @(negedge clk); stat_wr = 1'b0;
    chk(!stat_irq && irq_si, "R9 status write", {30'h0, stat_irq, irq_si}, 32'h1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk(!irq_si, "R9 ack", {31'h0, irq_si}, 32'h0);
  endtask

  task automatic t_store();
    int w0 = wcnt;
    for (int i = 0; i < 16; i++) wr_scr(i, 32'hC0DE_0000 + 32'h0103 * i);
    kick(1'b0, 1'b1, 32'h0000_4008);
    wait_idle();
    chk(wcnt - w0 == 16, "R1 write count", wcnt - w0, 16);
    for (int i = 0; i < 16; i++)
      chk(wlog[i] == bswap(32'hC0DE_0000 + 32'h0103 * i), "R3 store word", wlog[i],
          bswap(32'hC0DE_0000 + 32'h0103 * i));
    clear_irqs();
  endtask

  task automatic t_far();
    logic [31:0] v, v0;
    int r0 = rcnt;
    rd_scr(3, v0);
    kick(1'b1, 1'b0, SIZE + 32'h8);
    repeat (4) @(negedge clk);
    chk(!busy && rcnt == r0, "R4 dropped", rcnt - r0, 0);
    chk(!stat_irq && !irq_si, "R4 no irq", {30'h0, stat_irq, irq_si}, 32'h0);
    rd_scr(3, v);
    chk(v == v0, "R4 scratch kept", v, v0);
  endtask

  task automatic t_negative();
    logic [31:0] v;
    int r0 = rcnt, w0;
    kick(1'b1, 1'b0, 32'hFFFF_FFF3);
    wait_idle();
    chk(rcnt - r0 == 12, "R5 read count", rcnt - r0, 12);
    for (int i = 0; i < 4; i++) begin
      rd_scr(i, v);
      chk(v == 32'h0, "R5 zero fill", v, 32'h0);
    end
    for (int i = 4; i < 16; i++) begin
      rd_scr(i, v);
      chk(v == bswap(mdat(32'(4 * (i - 4)))), "R5 load tail", v, bswap(mdat(32'(4 * (i - 4)))));
    end
    clear_irqs();
    w0 = wcnt;
    kick(1'b0, 1'b1, 32'hFFFF_FFF0);
    wait_idle();
    chk(wcnt - w0 == 12, "R5 skip writes", wcnt - w0, 12);
    chk(wlog[4] == bswap(bswap(mdat(32'h0))), "R5 store tail", wlog[4], mdat(32'h0));
    clear_irqs();
  endtask

  task automatic t_delay();
    int n0 = 0, n1 = 0, r0;
    bp_en = 1'b0;
    repeat (2) @(negedge clk);
    kick(1'b1, 1'b0, 32'h100); n0 = 1;
    while (!irq_si && n0 < 20000) begin @(negedge clk); n0++; end
    clear_irqs();
    delay_en = 1'b1;
    kick(1'b1, 1'b0, 32'h100); n1 = 1;
    repeat (60) begin @(negedge clk); n1++; end
    chk(busy && !irq_si, "R8 busy during delay", {30'h0, busy, irq_si}, 32'h2);
    r0 = rcnt;
    @(negedge clk); go_dram = 1'b1; go_scr = 1'b1; n1++;
    @(negedge clk); go_dram = 1'b0; go_scr = 1'b0; n1++;
    repeat (3) begin @(negedge clk); n1++; end
    chk(rcnt == r0 && !req_valid, "R8 trigger ignored", rcnt - r0, 0);
    while (!irq_si && n1 < 20000) begin @(negedge clk); n1++; end
    chk(n1 - n0 == DELAY, "R7 delay length", n1 - n0, DELAY);
    chk(stat_irq && !busy, "R7 R8 done after delay", {30'h0, stat_irq, busy}, 32'h2);
    delay_en = 1'b0;
    clear_irqs();
    bp_en = 1'b1;
  endtask

  task automatic t_both();
    int r0 = rcnt, w0 = wcnt;
    kick(1'b1, 1'b1, 32'h200);
    wait_idle();
    chk(rcnt - r0 == 16 && wcnt == w0, "R11 scratch direction first", rcnt - r0, 16);
    clear_irqs();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_aligned();
    t_clear();
    t_store();
    t_far();
    t_negative();
    t_delay();
    t_both();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule